// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces two operand addresses every clock cycle. Both generators draw on one shared bank of four register sets. Each set holds an index, a length, a base and a modify value, all 32 bits wide. Each generator names a set and an addressing mode. It then drives an address straight from that set's registers, and it may rewrite the set's index at the next clock edge.

Any set with a non-zero length acts as its own circular buffer. Post-modify updates on that set fold back into the window from base to base plus length minus one. A set whose length is zero moves linearly. The bit-reversed mode carries from the most significant bit downward, which walks an index through the reordering used by FFT stages.

Software loads the registers through one write port, one register per cycle. Memory access and stack pointers are handled outside the block.

Top module: `circ_addr_gen`

## Requirements
- R1: While reset (rst_n low) is asserted, every register of every set is held at zero, so every mode reads address 0. Reset is asynchronous.
- R2: When ld_en is high, ld_data is written at the next clock edge into set ld_set. The register is chosen by ld_reg: 0 selects index, 1 length, 2 base, 3 modify.
- R3: Mode code 0 (plain indirect) drives the index as the address and leaves the index unchanged. Codes 5, 6 and 7 behave the same way.
- R4: Mode code 1 (post-increment) drives the old index. When length is zero, the index becomes index+modify mod 2^32 at the clock edge.
- R5: Mode code 2 (post-decrement) drives the old index. When length is zero, the index becomes index-modify mod 2^32.
- R6: For post-increment with non-zero length, compare the 33-bit sum index+modify with base+length. If the sum is greater or equal, length is subtracted once before the result is stored.
- R7: For post-decrement with non-zero length, if index-modify as a signed value is below base, length is added once before the result is stored.
- R8: Mode code 3 (indexed) drives index+modify mod 2^32 and leaves the index unchanged.
- R9: Mode code 4 (bit-reversed) drives the old index. The index becomes the sum of index and modify with the carry running from bit 31 toward bit 0. No circular correction is applied.
- R10: Both generators give their own address in the same cycle from their own selected sets. Their updates to different sets both take effect.
- R11: If a load targets an index in the same cycle as a generator update to it, the load wins. If both generators update the same index, generator A's result is stored.
- R12: With a_en or b_en low, that generator still drives its address but changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Register load strobe |
| ld_set | input | 2 | Set to load |
| ld_reg | input | 2 | Register in set: 0 index, 1 length, 2 base, 3 modify |
| ld_data | input | 32 | Load value |
| a_en | input | 1 | Generator A update enable |
| a_set | input | 2 | Generator A set select |
| a_mode | input | 3 | Generator A mode code |
| a_addr | output | 32 | Generator A address |
| b_en | input | 1 | Generator B update enable |
| b_set | input | 2 | Generator B set select |
| b_mode | input | 3 | Generator B mode code |
| b_addr | output | 32 | Generator B address |

## Verification
Both addresses are combinational from the current registers and the selects, so each is due in the same cycle its selects are driven. Index updates and loads show up one clock edge later. The bench drives inputs just after the falling edge and compares both addresses with its model one nanosecond later. It advances the model only after the following rising edge, so every effect of a load or update is first compared in the cycle after it. The directed steps cover wrap in both directions, the load and generator priority, the bit-reversed carry and the reserved codes. A long stretch of random traffic then runs against the same model.

// File: rtl/circ_addr_gen.sv
module circ_addr_gen #(
  parameter int AW    = 32,
  parameter int NSETS = 4,
  parameter int SW    = $clog2(NSETS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_set,
  input  logic [1:0]    ld_reg,
  input  logic [AW-1:0] ld_data,
  input  logic          a_en,
  input  logic [SW-1:0] a_set,
  input  logic [2:0]    a_mode,
  output logic [AW-1:0] a_addr,
  input  logic          b_en,
  input  logic [SW-1:0] b_set,
  input  logic [2:0]    b_mode,
  output logic [AW-1:0] b_addr
);
  localparam int RI = 0, RL = 1, RB = 2, RM = 3;

  logic [NSETS-1:0][3:0][AW-1:0] rf;

  function automatic logic [AW-1:0] rev(input logic [AW-1:0] v);
    for (int k = 0; k < AW; k++) rev[k] = v[AW-1-k];
  endfunction

  function automatic logic [AW-1:0] step_idx(input logic [2:0] md,
      input logic [AW-1:0] i, input logic [AW-1:0] l,
      input logic [AW-1:0] b, input logic [AW-1:0] m);
    logic [AW:0] s, lim;
    lim = {1'b0, b} + {1'b0, l};
    case (md)
      3'd1: begin
        s = {1'b0, i} + {1'b0, m};
        if (l != '0 && s >= lim) s = s - {1'b0, l};
      end
      3'd2: begin
        s = {1'b0, i} - {1'b0, m};
        if (l != '0 && (s[AW] || s < {1'b0, b})) s = s + {1'b0, l};
      end
      3'd4:    s = {1'b0, rev(rev(i) + rev(m))};
      default: s = {1'b0, i};
    endcase
    return s[AW-1:0];
  endfunction

  function automatic logic updates(input logic [2:0] md);
    return md == 3'd1 || md == 3'd2 || md == 3'd4;
  endfunction

  logic [AW-1:0] a_i, a_m, b_i, b_m, a_next, b_next;
  logic          a_upd, b_upd;

  assign a_i    = rf[a_set][RI];
  assign a_m    = rf[a_set][RM];
  assign b_i    = rf[b_set][RI];
  assign b_m    = rf[b_set][RM];
  assign a_addr = (a_mode == 3'd3) ? a_i + a_m : a_i;
  assign b_addr = (b_mode == 3'd3) ? b_i + b_m : b_i;
  assign a_upd  = a_en && updates(a_mode);
  assign b_upd  = b_en && updates(b_mode);
  assign a_next = step_idx(a_mode, a_i, rf[a_set][RL], rf[a_set][RB], a_m);
  assign b_next = step_idx(b_mode, b_i, rf[b_set][RL], rf[b_set][RB], b_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf <= '0;
    end else begin
      if (b_upd) rf[b_set][RI] <= b_next;
      if (a_upd) rf[a_set][RI] <= a_next;
      if (ld_en) rf[ld_set][ld_reg] <= ld_data;
    end
  end
endmodule

module circ_addr_gen_chk #(
  parameter int AW    = 32,
  parameter int NSETS = 4,
  parameter int SW    = $clog2(NSETS)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          ld_en,
  input logic [SW-1:0]                 ld_set,
  input logic [1:0]                    ld_reg,
  input logic [AW-1:0]                 ld_data,
  input logic                          a_en,
  input logic [SW-1:0]                 a_set,
  input logic [2:0]                    a_mode,
  input logic                          b_en,
  input logic [SW-1:0]                 b_set,
  input logic [2:0]                    b_mode,
  input logic [NSETS-1:0][3:0][AW-1:0] rf
);
  logic a_load_hit, a_any_load;
  assign a_load_hit = ld_en && ld_set == a_set && ld_reg == 2'd0;
  assign a_any_load = ld_en && ld_set == a_set;

  // R2
  load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> rf[$past(ld_set)][$past(ld_reg)] == $past(ld_data));

  // R3
  indirect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_mode == 3'd0 && !a_load_hit && !(b_en && b_set == a_set))
    |=> rf[$past(a_set)][0] == $past(rf[a_set][0]));

  // R4
  linear_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_mode == 3'd1 && rf[a_set][1] == '0 && !a_load_hit)
    |=> rf[$past(a_set)][0] == $past(rf[a_set][0] + rf[a_set][3]));

  // R6
  wrap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_mode == 3'd1 && rf[a_set][1] != '0 && !a_any_load &&
     rf[a_set][0] >= rf[a_set][2] &&
     rf[a_set][0] - rf[a_set][2] < rf[a_set][1] &&
     rf[a_set][3] < rf[a_set][1] &&
     ({1'b0, rf[a_set][2]} + {1'b0, rf[a_set][1]}) <= {1'b1, {AW{1'b0}}})
    |=> (rf[$past(a_set)][0] >= rf[$past(a_set)][2] &&
         rf[$past(a_set)][0] - rf[$past(a_set)][2] < rf[$past(a_set)][1]));
endmodule

bind circ_addr_gen circ_addr_gen_chk #(.AW(AW), .NSETS(NSETS), .SW(SW)) u_chk (.*);

// File: tb/circ_addr_gen_test.sv
module circ_addr_gen_test;
  logic        clk = 0, rst_n = 0;
  logic        ld_en = 0, a_en = 0, b_en = 0;
  logic [1:0]  ld_set = 0, ld_reg = 0, a_set = 0, b_set = 0;
  logic [2:0]  a_mode = 0, b_mode = 0;
  logic [31:0] ld_data = 0;
  logic [31:0] a_addr, b_addr;
  int checks = 0, errors = 0;
  longint mdl [4][4];
  localparam longint MASK = 64'hFFFF_FFFF;

  always #2.5 clk = ~clk;

  circ_addr_gen uut (.*);

  function automatic longint rv(input longint v);
    longint r = 0;
    for (int k = 0; k < 32; k++) if (v[k]) r |= (64'd1 << (31 - k));
    return r;
  endfunction

  function automatic longint nxt(input int s, input int md);
    longint i = mdl[s][0], l = mdl[s][1], b = mdl[s][2], m = mdl[s][3], t;
    if (md == 1) begin t = i + m; if (l != 0 && t >= b + l) t -= l; end
    else if (md == 2) begin t = i - m; if (l != 0 && t < b) t += l; end
    else if (md == 4) t = rv((rv(i) + rv(m)) & MASK);
    else t = i;
    return t & MASK;
  endfunction

  function automatic longint eaddr(input int s, input int md);
    return (md == 3) ? ((mdl[s][0] + mdl[s][3]) & MASK) : mdl[s][0];
  endfunction

  task automatic chk(input string tg, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tg, got, exp);
    end
  endtask

  task automatic step(input string tg,
      input bit ae, input int as, input int am,
      input bit be, input int bs, input int bm,
      input bit le = 0, input int ls = 0, input int lr = 0, input longint ldv = 0);
    longint na, nb;
    @(negedge clk);
    a_en = ae; a_set = as[1:0]; a_mode = am[2:0];
    b_en = be; b_set = bs[1:0]; b_mode = bm[2:0];
    ld_en = le; ld_set = ls[1:0]; ld_reg = lr[1:0]; ld_data = ldv[31:0];
    #1;
    chk({tg, " addrA"}, longint'(a_addr), eaddr(as, am));
    chk({tg, " addrB"}, longint'(b_addr), eaddr(bs, bm));
    na = nxt(as, am);
    nb = nxt(bs, bm);
    @(posedge clk);
    if (be && (bm == 1 || bm == 2 || bm == 4)) mdl[bs][0] = nb;
    if (ae && (am == 1 || am == 2 || am == 4)) mdl[as][0] = na;
    if (le) mdl[ls][lr] = ldv & MASK;
  endtask

  task automatic load(input string tg, input int s, input int r, input longint v);
    step(tg, 0, 0, 0, 0, 0, 0, 1, s, r, v);
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) for (int r = 0; r < 4; r++) mdl[s][r] = 0;
    #7;
    chk("R1 reset addrA", longint'(a_addr), 0);
    chk("R1 reset addrB", longint'(b_addr), 0);
    @(negedge clk); rst_n = 1;
    step("R1", 0, 1, 3, 0, 2, 3);
    // set 0: linear, set 1: circular 0x100..0x10F step 6
    load("R2", 0, 0, 32'h1000); load("R2", 0, 3, 4);
    load("R2", 1, 2, 32'h100); load("R2", 1, 1, 16);
    load("R2", 1, 0, 32'h10C); load("R2", 1, 3, 6);
    step("R3", 1, 0, 0, 1, 1, 0);
    step("R3", 1, 0, 5, 1, 1, 7);
    step("R4", 1, 0, 1, 0, 0, 0);
    step("R4", 1, 0, 1, 0, 0, 0);
    step("R5", 1, 0, 2, 0, 0, 0);
    step("R6", 1, 1, 1, 0, 0, 0);
    step("R6", 1, 1, 1, 0, 0, 0);
    step("R7", 1, 1, 2, 0, 0, 0);
    step("R7", 1, 1, 2, 0, 0, 0);
    step("R7", 1, 1, 2, 0, 0, 0);
    step("R8", 1, 1, 3, 0, 0, 3);
    step("R8", 0, 1, 0, 0, 0, 0);
    load("R5", 0, 0, 2); step("R5", 1, 0, 2, 0, 0, 0); step("R5", 0, 0, 0, 0, 0, 0);
    load("R9", 2, 3, 32'h0800_0000);
    step("R9", 1, 2, 4, 0, 0, 0); step("R9", 1, 2, 4, 0, 0, 0);
    step("R9", 1, 2, 4, 0, 0, 0); step("R9", 1, 2, 4, 0, 0, 0);
    step("R10", 1, 0, 1, 1, 1, 1);
    step("R10", 1, 1, 2, 1, 0, 2);
    step("R11 load", 1, 0, 1, 0, 0, 0, 1, 0, 0, 32'h55);
    step("R11 A over B", 1, 1, 1, 1, 1, 2);
    step("R11", 0, 1, 0, 0, 0, 0);
    step("R12", 0, 0, 1, 0, 1, 2);
    step("R12", 0, 0, 4, 0, 1, 1);
    step("R12", 1, 0, 0, 1, 1, 0);
    for (int n = 0; n < 3000; n++) begin
      bit le = ($urandom_range(0, 3) == 0);
      step("R10 random", $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 7),
           $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 7),
           le, $urandom_range(0, 3), $urandom_range(0, 3),
           ($urandom_range(0, 1) != 0) ? longint'($urandom_range(0, 40)) : longint'($urandom()));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule